// File: doc/BRIEF.md
# Multi-Select 128x8 Static RAM

This block is a small word-organised static memory meant to hang directly off a microprocessor bus. It holds 128 words of 8 bits each and is addressed by 7 lines. A read strobe and a write strobe, both active low, choose the access. Five chip-select lines of mixed polarity gate it: two are active high and three are active low. Several such memories can therefore share one bus, each one decoding a different slice of the address space with no external glue.

The shared bidirectional data bus is split into three parts for synthesis: a data-in port, a data-out port and an output-enable. A pad or bus wrapper turns them back into a three-state bus. The strobes are sampled on a clock rather than treated as asynchronous pulses. Writes are committed on the rising clock edge while the write condition holds. Reads are combinational from the current address and select state, so the bus is released in the same cycle the read condition ends.

Internally the store is laid out as 16 rows by 8 columns of words. The low four address bits pick the row, and the upper three bits pick the column bank. Memory contents are undefined after reset.

Top module: `msel_sram`

## Requirements
- R1: The store keeps 128 independent 8-bit words, addressed by the 7-bit `addr`. A word written at an address reads back unchanged at that address.
- R2: The part is selected only when `sel_pos[1:0]` is `2'b11` and `sel_neg[2:0]` is `3'b000` at the same time. With any other of the 31 combinations, `bus_oe` stays low and no write happens, whatever the strobes do.
- R3: When selected with `rd_n` low, the block is in read mode whatever the level of `wr_n`. In read mode `bus_oe` is high, `dout` carries the word stored at `addr`, and no write happens on the clock edge.
- R4: When selected with `rd_n` high and `wr_n` low, `din` is stored at `addr` on the rising clock edge. The new value can be read from the very next cycle.
- R5: When selected with both `rd_n` and `wr_n` high (standby), `bus_oe` is low and nothing is written.
- R6: `bus_oe` and `dout` are combinational in the address, the selects and `rd_n`. A new address is reflected in the same cycle, and the bus is released in the same cycle that `rd_n` rises or the selects drop.
- R7: A write changes only the addressed word. All other 127 words keep their values.
- R8: With the default `ZERO_IDLE` setting, `dout` is all zeros whenever `bus_oe` is low.
- R9: While `rst_n` is low, `bus_oe` is low and writes are blocked. Stored words are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks access while low |
| addr | input | 7 | Word address (low 4 bits row, upper 3 bits column bank) |
| rd_n | input | 1 | Read strobe, active low, has priority over write |
| wr_n | input | 1 | Write strobe, active low |
| sel_pos | input | 2 | Active-high chip selects |
| sel_neg | input | 3 | Active-low chip selects |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| bus_oe | output | 1 | Drive enable for the shared bus |

## Verification
On every cycle the assertions check the following: the bus enable rises only under a full select, it follows the read condition directly, standby and deselection release the bus, idle output is zero, and a word written in one cycle is returned when the next cycle reads the same address. Only the bench scenarios can show that the whole address space keeps 128 distinct words. The same is true of a write touching no neighbour, of each of the 31 illegal select patterns leaving memory unchanged, of read priority suppressing a write with both strobes low, and of a reset pulse leaving prior contents intact.

// File: rtl/msel_sram_pkg.sv
package msel_sram_pkg;
   typedef enum logic [1:0] {
      ACC_OFF   = 2'd0,
      ACC_IDLE  = 2'd1,
      ACC_READ  = 2'd2,
      ACC_WRITE = 2'd3
   } acc_mode_e;
endpackage

// File: rtl/msel_sram_decode.sv
module msel_sram_decode
   import msel_sram_pkg::*;
#(
   parameter int NPOS = 2,
   parameter int NNEG = 3
) (
   input  logic            rst_n,
   input  logic [NPOS-1:0] sel_pos,
   input  logic [NNEG-1:0] sel_neg,
   input  logic            rd_n,
   input  logic            wr_n,
   output acc_mode_e       mode
);
   logic picked;

   // every active-high select high and every active-low select low
   assign picked = rst_n && (&sel_pos) && !(|sel_neg);

   always_comb begin
      if (!picked)     mode = ACC_OFF;
      else if (!rd_n)  mode = ACC_READ;   // read wins over write
      else if (!wr_n)  mode = ACC_WRITE;
      else             mode = ACC_IDLE;
   end
endmodule

// File: rtl/msel_sram_array.sv
module msel_sram_array #(
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   parameter int COL_W  = 3
) (
   input  logic                   clk,
   input  logic                   we,
   input  logic [ROW_W+COL_W-1:0] addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata
);
   localparam int ROWS = 1 << ROW_W;
   localparam int COLS = 1 << COL_W;

   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;
   logic [DATA_W-1:0] bank_rd [COLS];

   assign row = addr[ROW_W-1:0];
   assign col = addr[ROW_W+COL_W-1:ROW_W];

   for (genvar c = 0; c < COLS; c++) begin : g_bank
      logic [DATA_W-1:0] cells [ROWS];
      logic              bank_we;

      assign bank_we = we && (col == COL_W'(c));

      always_ff @(posedge clk) begin
         if (bank_we) cells[row] <= wdata;
      end

      assign bank_rd[c] = cells[row];
   end

   assign rdata = bank_rd[col];
endmodule

// File: rtl/msel_sram.sv
module msel_sram
   import msel_sram_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 7,
   parameter int ROW_W     = 4,
   parameter int NPOS      = 2,
   parameter int NNEG      = 3,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [NPOS-1:0]   sel_pos,
   input  logic [NNEG-1:0]   sel_neg,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              bus_oe
);
   localparam int COL_W = ADDR_W - ROW_W;

   if (DATA_W < 1)                    begin : g_bad_data $error("DATA_W must be positive"); end
   if (ROW_W < 1 || ROW_W >= ADDR_W)  begin : g_bad_row  $error("ROW_W must lie in 1..ADDR_W-1"); end
   if (NPOS < 1 || NNEG < 1)          begin : g_bad_sel  $error("need at least one select of each polarity"); end

   acc_mode_e         mode;
   logic [DATA_W-1:0] rdata;

   msel_sram_decode #(.NPOS(NPOS), .NNEG(NNEG)) u_decode (
      .rst_n   (rst_n),
      .sel_pos (sel_pos),
      .sel_neg (sel_neg),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .mode    (mode)
   );

   msel_sram_array #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
      .clk   (clk),
      .we    (mode == ACC_WRITE),
      .addr  (addr),
      .wdata (din),
      .rdata (rdata)
   );

   assign bus_oe = (mode == ACC_READ);

   if (ZERO_IDLE) begin : g_gate_out
      assign dout = bus_oe ? rdata : '0;
   end else begin : g_raw_out
      assign dout = rdata;
   end
endmodule

// File: rtl/msel_sram_chk.sv
module msel_sram_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 7,
   parameter int NPOS      = 2,
   parameter int NNEG      = 3,
   parameter bit ZERO_IDLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_n,
   input logic              wr_n,
   input logic [NPOS-1:0]   sel_pos,
   input logic [NNEG-1:0]   sel_neg,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic              bus_oe
);
   logic              full_sel;
   logic              wr_seen;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   assign full_sel = (&sel_pos) && !(|sel_neg);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_seen <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_seen <= full_sel && rd_n && !wr_n;
         wr_addr <= addr;
         wr_data <= din;
      end
   end

   p_oe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> full_sel);

   p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_sel && !rd_n) |-> bus_oe);

   p_write_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_seen && bus_oe && addr == wr_addr) |-> (dout == wr_data));

   p_strobe_high_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !bus_oe);

   if (ZERO_IDLE) begin : g_zero_chk
      p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_oe |-> (dout == '0));
   end

   always_comb begin
      if (!rst_n) begin
         p_reset_quiet_r9: assert (!bus_oe);
      end
   end
endmodule

bind msel_sram msel_sram_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPOS(NPOS), .NNEG(NNEG), .ZERO_IDLE(ZERO_IDLE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
   .sel_pos(sel_pos), .sel_neg(sel_neg), .din(din), .dout(dout), .bus_oe(bus_oe)
);

// File: tb/msel_sram_test.sv
module msel_sram_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [6:0] addr;
   logic       rd_n, wr_n;
   logic [1:0] sel_pos;
   logic [2:0] sel_neg;
   logic [7:0] din;
   logic [7:0] dout;
   logic       bus_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [8:0] exp_q [$];   // {oe, data}
   string      req_q [$];
   logic [7:0] model [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   msel_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
      .sel_pos(sel_pos), .sel_neg(sel_neg), .din(din), .dout(dout), .bus_oe(bus_oe)
   );

   // monitor: compare at the falling edge of the cycle the item was driven in
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [8:0] e;
         string      r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         checks++;
         if ({bus_oe, dout} !== e) begin
            errors++;
            $display("FAIL %s: got oe=%0b dout=%02h, expected oe=%0b dout=%02h",
                     r, bus_oe, dout, e[8], e[7:0]);
         end
      end
   end

   task automatic drive(input logic [1:0] sp, input logic [2:0] sn, input logic r,
                        input logic w, input logic [6:0] a, input logic [7:0] d);
      @(posedge clk);
      #1;
      sel_pos = sp; sel_neg = sn; rd_n = r; wr_n = w; addr = a; din = d;
   endtask

   task automatic expect_bus(input logic oe, input logic [7:0] d, input string r);
      exp_q.push_back({oe, oe ? d : 8'h00});
      req_q.push_back(r);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      drive(2'b11, 3'b000, 1'b1, 1'b0, a, d);
      model[a] = d;
   endtask

   task automatic rd(input logic [6:0] a, input string r);
      drive(2'b11, 3'b000, 1'b0, 1'b1, a, 8'h00);
      expect_bus(1'b1, model[a], r);
   endtask

   function automatic logic [7:0] pat(input int a, input int k);
      return 8'((a * 37 + k * 91 + 5) ^ (a >> 2));
   endfunction

   initial begin
      rst_n = 1'b0;
      sel_pos = 2'b11; sel_neg = 3'b000; rd_n = 1'b0; wr_n = 1'b1; addr = '0; din = '0;
      // R9: bus stays released during reset even with a full read request
      drive(2'b11, 3'b000, 1'b0, 1'b1, 7'd3, 8'h00);
      expect_bus(1'b0, 8'h00, "R9 reset quiet");
      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd0, 8'h00);
      rst_n = 1'b1;

      // R1/R4: fill every word, read every word back
      for (int a = 0; a < 128; a++) wr(7'(a), pat(a, 0));
      for (int a = 0; a < 128; a++) rd(7'(a), "R1 R4 fill readback");

      // R4: overwrite then read in the very next cycle
      wr(7'd77, 8'h5A);
      rd(7'd77, "R4 next-cycle read");

      // R3: both strobes low -> read, no write
      drive(2'b11, 3'b000, 1'b0, 1'b0, 7'd20, 8'hFF ^ model[20]);
      expect_bus(1'b1, model[20], "R3 read priority");
      rd(7'd20, "R3 no write during read");

      // R5/R8: standby releases bus, zero output, no write
      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd21, ~model[21]);
      expect_bus(1'b0, 8'h00, "R5 R8 standby");
      rd(7'd21, "R5 standby no write");

      // R6: address change and strobe rise act in the same cycle
      rd(7'd10, "R6 read A");
      rd(7'd90, "R6 address follows");
      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd90, 8'h00);
      expect_bus(1'b0, 8'h00, "R6 release on strobe rise");
      rd(7'd90, "R6 read again");
      drive(2'b10, 3'b000, 1'b0, 1'b1, 7'd90, 8'h00);
      expect_bus(1'b0, 8'h00, "R6 release on deselect");

      // R2: every illegal select pattern blocks read drive and write
      for (int c = 0; c < 32; c++) begin
         if (c != 5'b00011) begin
            drive(2'(c), 3'(c >> 2), 1'b0, 1'b1, 7'(c + 40), 8'h00);
            expect_bus(1'b0, 8'h00, "R2 illegal select read");
            drive(2'(c), 3'(c >> 2), 1'b1, 1'b0, 7'(c + 40), ~model[c + 40]);
            rd(7'(c + 40), "R2 illegal select write blocked");
         end
      end

      // R7: a single write leaves all other words intact
      wr(7'd63, 8'hC3);
      for (int a = 0; a < 128; a++) rd(7'(a), "R7 isolation");

      // R9: reset pulse blocks write and keeps contents
      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd5, 8'h00);
      rst_n = 1'b0;
      drive(2'b11, 3'b000, 1'b1, 1'b0, 7'd5, ~model[5]);
      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd5, 8'h00);
      rst_n = 1'b1;
      rd(7'd5, "R9 reset keeps contents");

      drive(2'b11, 3'b000, 1'b1, 1'b1, 7'd0, 8'h00);
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule